// File: doc/BRIEF.md
# Host Command Interface with Polled Status

This block sits behind a telegram router and takes host commands. Each command telegram carries a command code and then up to eight parameter bytes. The block gathers the whole telegram in a staging buffer. Nothing runs until the router signals the stop condition. At that point the block checks the code against its table of supported commands and hands the code and parameters to an execution engine.

The engine here is a stand-in. Its run time depends on the number of parameters, and it knows three operations. While a command runs, the status byte shows a wait flag. The host polls this byte until the flag drops, and only then reads the result bytes through an indexed read port. The status byte also reports an unsupported code and a command that ran but found no data. A separate valid output tells the host whether the result bytes may be used.

Top module: `cmd_host_if`

## Requirements
- R1: After reset the status byte is 0x00, rd_valid is 0 and every result slot reads 0x00.
- R2: The first byte written after a stop (or after reset) is the command code and each later byte is a parameter; the wait flag never rises before the stop strobe of that telegram.
- R3: On a stop that ends a telegram with a supported code while idle, status bit 0 (wait) reads 1 from the clock edge that samples the stop through the next BASE_LAT+n-1 edges, where n is the number of parameters kept; it reads 0 from edge BASE_LAT+n onward (BASE_LAT = 4).
- R4: A telegram whose code is none of 0x10, 0x11, 0x12 sets status bit 1 (invalid) at the edge that samples the stop, leaves wait at 0 and leaves rd_valid at 0.
- R5: Code 0x12 with zero parameters finishes with status bit 2 (no data) set, wait clear and rd_valid 0.
- R6: On success rd_valid goes to 1 and the result slots hold: code 0x10 the parameters unchanged; code 0x11 the bitwise inverse of each parameter; code 0x12 the 8-bit wrapping sum of the parameters in slot 0. Slots not written this way read 0x00.
- R7: The status byte is {5'b0, no data, invalid, wait}; bits 7 to 3 always read 0.
- R8: A telegram that ends while wait is set is dropped: the status does not change, the running command finishes on time, and its results are unaffected.
- R9: Parameter bytes beyond the eighth are discarded; the command sees only the first eight, and its latency uses n = 8.
- R10: A stop strobe with no preceding byte in the telegram changes neither the status, rd_valid nor the results.
- R11: An accepted telegram clears the invalid and no-data flags and rd_valid at the edge that samples its stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_we | input | 1 | A telegram byte is present on byte_data |
| byte_data | input | 8 | Telegram byte from the router |
| stop_i | input | 1 | Stop condition strobe that ends the telegram |
| rd_idx | input | 3 | Result slot to read |
| rd_data | output | 8 | Result byte at rd_idx (combinational) |
| status | output | 8 | Status byte {5'b0, no data, invalid, wait} |
| rd_valid | output | 1 | Result bytes belong to a command that completed successfully |

## Verification
Three result timings are checked. The invalid flag and the wait flag appear at the edge that samples the stop. The wait flag then holds for BASE_LAT+n-1 more edges and drops on the next edge. The final flags, rd_valid and the result bytes change on that same edge. The bench drives and samples on falling edges. It counts the rising edges after the stop to the cycle the rules give and checks wait once on each side of the edge where it clears. The result port is combinational, so reads are sampled a short delay after rd_idx changes, well clear of the next rising edge.

// File: rtl/chi_pkg.sv
package chi_pkg;
    localparam int DW        = 8;
    localparam int NUM_CMDS  = 3;

    localparam logic [DW-1:0] OP_ECHO   = 8'h10;
    localparam logic [DW-1:0] OP_INVERT = 8'h11;
    localparam logic [DW-1:0] OP_SUM    = 8'h12;

    // supported codes, entry 0 in the low byte
    localparam logic [NUM_CMDS-1:0][DW-1:0] OP_TABLE = {OP_SUM, OP_INVERT, OP_ECHO};

    localparam int ST_WAIT    = 0;
    localparam int ST_INVALID = 1;
    localparam int ST_NODATA  = 2;
endpackage

// File: rtl/chi_collect.sv
module chi_collect
    import chi_pkg::*;
#(
    parameter int NP = 8,
    localparam int CW = $clog2(NP + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_we,
    input  logic [DW-1:0]          byte_data,
    input  logic                   stop_i,
    output logic                   tel_end,
    output logic [DW-1:0]          tel_code,
    output logic [CW-1:0]          tel_cnt,
    output logic [NP-1:0][DW-1:0]  tel_par
);
    typedef struct packed {
        logic                  have;
        logic [DW-1:0]         code;
        logic [CW-1:0]         cnt;
        logic [NP-1:0][DW-1:0] par;
    } col_t;

    col_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stop_i) begin
            s_d = '0;
        end else if (byte_we) begin
            if (!s_q.have) begin
                s_d.have = 1'b1;
                s_d.code = byte_data;
            end else if (s_q.cnt < CW'(NP)) begin
                for (int i = 0; i < NP; i++) begin
                    if (s_q.cnt == CW'(i)) s_d.par[i] = byte_data;
                end
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tel_end  = stop_i & s_q.have;
    assign tel_code = s_q.code;
    assign tel_cnt  = s_q.cnt;
    assign tel_par  = s_q.par;
endmodule

// File: rtl/chi_engine.sv
module chi_engine
    import chi_pkg::*;
#(
    parameter int NP       = 8,
    parameter int BASE_LAT = 4,
    localparam int CW = $clog2(NP + 1),
    localparam int LW = $clog2(BASE_LAT + NP + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic [DW-1:0]          go_code,
    input  logic [CW-1:0]          go_cnt,
    input  logic [NP-1:0][DW-1:0]  go_par,
    output logic                   code_ok,
    output logic                   done,
    output logic                   nodata,
    output logic [NP-1:0][DW-1:0]  res
);
    typedef struct packed {
        logic                  busy;
        logic [LW-1:0]         left;
        logic [DW-1:0]         code;
        logic [CW-1:0]         n;
        logic [NP-1:0][DW-1:0] par;
    } eng_t;

    eng_t e_d, e_q;
    logic [NUM_CMDS-1:0] hit;
    logic [DW-1:0]       acc;

    for (genvar g = 0; g < NUM_CMDS; g++) begin : g_tab
        assign hit[g] = (go_code == OP_TABLE[g]);
    end
    assign code_ok = |hit;

    always_comb begin
        e_d = e_q;
        if (go) begin
            e_d.busy = 1'b1;
            e_d.left = LW'(BASE_LAT) + LW'(go_cnt) - LW'(1);
            e_d.code = go_code;
            e_d.n    = go_cnt;
            e_d.par  = go_par;
        end else if (e_q.busy) begin
            if (e_q.left == '0) e_d.busy = 1'b0;
            else                e_d.left = e_q.left - LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    always_comb begin
        res = '0;
        acc = '0;
        for (int i = 0; i < NP; i++) acc = acc + e_q.par[i];
        case (e_q.code)
            OP_ECHO:   res = e_q.par;
            OP_INVERT: begin
                for (int i = 0; i < NP; i++) begin
                    if (CW'(i) < e_q.n) res[i] = ~e_q.par[i];
                end
            end
            OP_SUM:    res[0] = acc;
            default:   res = '0;
        endcase
    end

    assign done   = e_q.busy && (e_q.left == '0);
    assign nodata = (e_q.code == OP_SUM) && (e_q.n == '0);
endmodule

// File: rtl/chi_ctrl.sv
module chi_ctrl
    import chi_pkg::*;
#(
    parameter int NP = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tel_end,
    input  logic                   code_ok,
    input  logic                   eng_done,
    input  logic                   eng_nodata,
    input  logic [NP-1:0][DW-1:0]  eng_res,
    output logic                   go,
    output logic [DW-1:0]          status,
    output logic                   rd_valid,
    output logic [NP-1:0][DW-1:0]  res
);
    typedef struct packed {
        logic                  busy_f;
        logic                  bad_f;
        logic                  nod_f;
        logic                  ok_f;
        logic [NP-1:0][DW-1:0] res;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        go  = 1'b0;
        if (c_q.busy_f) begin
            if (eng_done) begin
                c_d.busy_f = 1'b0;
                c_d.nod_f  = eng_nodata;
                c_d.ok_f   = !eng_nodata;
                if (!eng_nodata) c_d.res = eng_res;
            end
        end else if (tel_end) begin
            go         = code_ok;
            c_d.busy_f = code_ok;
            c_d.bad_f  = !code_ok;
            c_d.nod_f  = 1'b0;
            c_d.ok_f   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        status             = '0;
        status[ST_WAIT]    = c_q.busy_f;
        status[ST_INVALID] = c_q.bad_f;
        status[ST_NODATA]  = c_q.nod_f;
    end

    assign rd_valid = c_q.ok_f;
    assign res      = c_q.res;
endmodule

// File: rtl/cmd_host_if.sv
module cmd_host_if
    import chi_pkg::*;
#(
    parameter int NP       = 8,
    parameter int BASE_LAT = 4,
    localparam int CW = $clog2(NP + 1),
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_we,
    input  logic [7:0]    byte_data,
    input  logic          stop_i,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic [7:0]    status,
    output logic          rd_valid
);
    logic                  tel_end;
    logic [DW-1:0]         tel_code;
    logic [CW-1:0]         tel_cnt;
    logic [NP-1:0][DW-1:0] tel_par;
    logic                  go;
    logic                  code_ok;
    logic                  eng_done;
    logic                  eng_nodata;
    logic [NP-1:0][DW-1:0] eng_res;
    logic [NP-1:0][DW-1:0] res;

    chi_collect #(.NP(NP)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_we   (byte_we),
        .byte_data (byte_data),
        .stop_i    (stop_i),
        .tel_end   (tel_end),
        .tel_code  (tel_code),
        .tel_cnt   (tel_cnt),
        .tel_par   (tel_par)
    );

    chi_engine #(.NP(NP), .BASE_LAT(BASE_LAT)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .go_code (tel_code),
        .go_cnt  (tel_cnt),
        .go_par  (tel_par),
        .code_ok (code_ok),
        .done    (eng_done),
        .nodata  (eng_nodata),
        .res     (eng_res)
    );

    chi_ctrl #(.NP(NP)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tel_end    (tel_end),
        .code_ok    (code_ok),
        .eng_done   (eng_done),
        .eng_nodata (eng_nodata),
        .eng_res    (eng_res),
        .go         (go),
        .status     (status),
        .rd_valid   (rd_valid),
        .res        (res)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NP; i++) begin
            if (rd_idx == IW'(i)) rd_data = res[i];
        end
    end
endmodule

// File: rtl/chi_check.sv
module chi_check (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_i,
    input logic [7:0] status,
    input logic       rd_valid,
    input logic       eng_done
);
    // R2: wait only rises on the edge that samples a stop
    a_r2_wait_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(stop_i));

    // R4: invalid excludes wait and valid results
    a_r4_invalid_alone: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> (!status[0] && !rd_valid));

    // R5: no data excludes wait and valid results
    a_r5_nodata_alone: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> (!status[0] && !rd_valid));

    // R6: valid results come with a clean status byte
    a_r6_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (status == 8'h00));

    // R8: a stop while busy does not end the wait early
    a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && stop_i && !eng_done) |=> status[0]);

    // R11: a new accepted command starts with flags cleared
    a_r11_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> (!rd_valid && status[2:1] == 2'b00));
endmodule

bind cmd_host_if chi_check u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_i   (stop_i),
    .status   (status),
    .rd_valid (rd_valid),
    .eng_done (eng_done)
);

// File: tb/cmd_host_if_bench.sv
module cmd_host_if_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_i = 1'b0;
    logic [2:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic [7:0] status;
    logic       rd_valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cmd_host_if u_cmd_host_if (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_we   (byte_we),
        .byte_data (byte_data),
        .stop_i    (stop_i),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .status    (status),
        .rd_valid  (rd_valid)
    );

    typedef struct packed {
        logic [7:0] code;
        logic [3:0] n;
        logic [7:0] base;
        logic [7:0] stat;
        logic       ok;
        logic [7:0] r0;
        logic [7:0] r1;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'h10, 4'd3,  8'h21, 8'h00, 1'b1, 8'h21, 8'h22},
        '{8'h11, 4'd2,  8'h0F, 8'h00, 1'b1, 8'hF0, 8'hEF},
        '{8'h12, 4'd4,  8'h01, 8'h00, 1'b1, 8'h0A, 8'h00},
        '{8'h12, 4'd0,  8'h00, 8'h04, 1'b0, 8'h00, 8'h00},
        '{8'h55, 4'd2,  8'h07, 8'h02, 1'b0, 8'h00, 8'h00},
        '{8'h10, 4'd10, 8'h80, 8'h00, 1'b1, 8'h80, 8'h81},
        '{8'h11, 4'd0,  8'h00, 8'h00, 1'b1, 8'h00, 8'h00},
        '{8'h13, 4'd0,  8'h00, 8'h02, 1'b0, 8'h00, 8'h00},
        '{8'h12, 4'd8,  8'hF0, 8'h00, 1'b1, 8'h9C, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_we   = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_we   = 1'b0;
    endtask

    task automatic send_stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [2:0] idx, input logic [7:0] exp);
        rd_idx = idx;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
        read_chk("R1 slot 0", 3'd0, 8'h00);
        read_chk("R1 slot 7", 3'd7, 8'h00);

        for (int k = 0; k < 9; k++) begin
            vec_t v;
            int   lat;
            v = VECS[k];
            send_byte(v.code);
            for (int j = 0; j < int'(v.n); j++) send_byte(v.base + 8'(j));
            chk("R2 no wait before stop", {7'b0, status[0]}, 8'h00);
            send_stop();
            if (v.stat == 8'h02) begin
                chk("R4 invalid status", status, 8'h02);
                chk("R4 rd_valid", {7'b0, rd_valid}, 8'h00);
                chk("R7 upper bits", status & 8'hF8, 8'h00);
            end else begin
                lat = 4 + ((v.n > 4'd8) ? 8 : int'(v.n));
                chk("R3 R11 wait set, flags cleared", status, 8'h01);
                chk("R11 rd_valid cleared", {7'b0, rd_valid}, 8'h00);
                repeat (lat - 1) @(negedge clk);
                chk("R3 wait held to last cycle", {7'b0, status[0]}, 8'h01);
                @(negedge clk);
                chk((v.stat == 8'h04) ? "R5 final status" : "R3 final status", status, v.stat);
                chk((v.ok) ? "R6 rd_valid" : "R5 rd_valid", {7'b0, rd_valid}, {7'b0, v.ok});
                if (v.ok) begin
                    read_chk("R6 slot 0", 3'd0, v.r0);
                    read_chk("R6 slot 1", 3'd1, v.r1);
                end
            end
        end

        // R9: nine parameters, ninth discarded, latency uses eight
        send_byte(8'h10);
        for (int j = 0; j < 9; j++) send_byte(8'h30 + 8'(j));
        send_stop();
        repeat (11) @(negedge clk);
        chk("R9 wait at edge 11", {7'b0, status[0]}, 8'h01);
        @(negedge clk);
        chk("R9 done at edge 12", status, 8'h00);
        read_chk("R9 slot 7 keeps eighth", 3'd7, 8'h37);
        read_chk("R9 slot 0", 3'd0, 8'h30);

        // R6: unused slot reads zero
        send_byte(8'h10);
        send_byte(8'h5A);
        send_stop();
        repeat (5) @(negedge clk);
        chk("R6 single echo valid", {7'b0, rd_valid}, 8'h01);
        read_chk("R6 slot 0", 3'd0, 8'h5A);
        read_chk("R6 unused slot 5", 3'd5, 8'h00);

        // R10: bare stop
        send_stop();
        @(negedge clk);
        chk("R10 status", status, 8'h00);
        chk("R10 rd_valid", {7'b0, rd_valid}, 8'h01);
        read_chk("R10 slot 0", 3'd0, 8'h5A);

        // R8: telegram during wait is dropped
        send_byte(8'h10);
        send_byte(8'h40);
        send_byte(8'h41);
        send_stop();
        send_byte(8'h11);
        send_byte(8'h01);
        send_byte(8'h02);
        send_stop();
        chk("R8 status after dropped stop", status, 8'h01);
        @(negedge clk);
        chk("R8 wait still held", status, 8'h01);
        @(negedge clk);
        chk("R8 finished on time", status, 8'h00);
        chk("R8 rd_valid", {7'b0, rd_valid}, 8'h01);
        read_chk("R8 slot 0 original", 3'd0, 8'h40);
        read_chk("R8 slot 1 original", 3'd1, 8'h41);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule